// File: doc/BRIEF.md
# Thread-Partitioned Instruction Fetch Buffer

This block holds fetched instructions between the fetch stage and decode in a core that runs several hardware threads at once. One physical array of 128 instruction slots is divided into private circular regions, one for each active thread. A 2-bit threading mode selects how many threads are active and how large each region is. A write group is never split: either the whole group fits in the target thread's region or none of it is stored. No thread can ever spill into another thread's space.

Each cycle, fetch may present a group of one to eight instructions tagged with a thread number. In the same cycle, decode may ask for up to eight of the oldest instructions of one thread. Both results are combinational: `wr_accept_o` tells fetch whether its group was taken, and `rd_num_o` with `rd_data_o` tells decode how many instructions it receives. The stored state moves on at the clock edge. Each thread can be flushed on its own. When all eight threads run, the block drives a flag that turns off instruction prefetch.

Top module: `smtfb_top`

## Requirements
- R1: A write group with `wr_cnt_i` from 1 to 8 is accepted (`wr_accept_o`=1 in that cycle) only when the target thread is active and its region has at least `wr_cnt_i` free slots. A count of 0 or above 8 is never accepted, and a group that does not fit is rejected whole, with nothing stored.
- R2: The mode encoding gives the active threads and the capacity of each: 0 means thread 0 only with 64 slots; 1 means threads 0 and 1 with 64 slots each; 2 means threads 0 to 3 with 32 slots each; 3 means threads 0 to 7 with 16 slots each. An inactive thread never accepts a write.
- R3: A read request returns `rd_num_o` = min(`rd_cnt_i` capped at 8, occupancy of `rd_tid_i`) instructions in the same cycle. Lane 0 of `rd_data_o` (bits 15:0) holds the oldest instruction, and the lanes follow in write order, also across the wrap of the region. The returned instructions leave the buffer at the next clock edge.
- R4: Writing, reading or flushing one thread leaves the stored contents and occupancy of every other thread unchanged.
- R5: `empty_o[t]` is 1 when thread t holds nothing. `full_o[t]` is 1 when thread t's occupancy equals its capacity, and an inactive thread has a capacity of 0, so it reports both full and empty.
- R6: `flush_i[t]` empties thread t at the next edge. In that cycle a write to thread t is refused and a read of thread t returns nothing.
- R7: `prefetch_off_o` is 1 exactly while the applied mode is 3.
- R8: A new value on `mode_i` takes effect at the next edge only if every thread is empty. Otherwise the mode is kept and `mode_err_o` is 1 in the following cycle. No write is accepted in any cycle in which `mode_i` differs from the applied mode.
- R9: After reset the applied mode is 0, all threads are empty, `full_o` is 8'hFE, and `mode_err_o` and `prefetch_off_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Requested threading mode |
| wr_valid_i | input | 1 | Write group present |
| wr_tid_i | input | 3 | Thread of the write group |
| wr_cnt_i | input | 4 | Number of instructions in the group |
| wr_data_i | input | 128 | Group lanes, lane i in bits 16i+15:16i |
| wr_accept_o | output | 1 | Group taken this cycle |
| rd_req_i | input | 1 | Read request |
| rd_tid_i | input | 3 | Thread to read |
| rd_cnt_i | input | 4 | Instructions wanted |
| rd_num_o | output | 4 | Instructions delivered |
| rd_data_o | output | 128 | Delivered lanes, oldest in lane 0 |
| flush_i | input | 8 | Per-thread flush |
| full_o | output | 8 | Per-thread full |
| empty_o | output | 8 | Per-thread empty |
| prefetch_off_o | output | 1 | Prefetch disable, set in eight-thread mode |
| mode_err_o | output | 1 | Mode change refused last cycle |

## Verification
The hardest cases to reach from the ports are a group that would cross the end of a region that is almost full, and a mode request made while a single thread still holds data. The stimulus first fills a region to its capacity and drains only part of it. It then offers groups that overshoot the remaining space by one slot, and after that groups that fit exactly and wrap around the end of the region. A draining read then shows that no partial group was stored. For the mode rules, a few instructions are left in thread 0 while the mode is changed. Flushes then empty the buffer so that each of the other modes can be entered and its region sizes checked.

// File: rtl/smtfb_pkg.sv
package smtfb_pkg;
  typedef enum logic [1:0] {
    SMT_ONE   = 2'd0,
    SMT_TWO   = 2'd1,
    SMT_FOUR  = 2'd2,
    SMT_EIGHT = 2'd3
  } smt_mode_e;

  // log2 of the number of regions the array is cut into
  function automatic int region_shift(smt_mode_e m);
    return (m == SMT_ONE) ? 1 : int'(m);
  endfunction

  function automatic int active_threads(smt_mode_e m);
    return 1 << int'(m);
  endfunction
endpackage

// File: rtl/smtfb_region.sv
module smtfb_region #(
  parameter int OW = 6,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [GW-1:0] push_n_i,
  input  logic [GW-1:0] pop_n_i,
  input  logic [OW-1:0] mask_i,
  output logic [OW-1:0] head_o,
  output logic [OW-1:0] tail_o,
  output logic [OW:0]   count_o
);
  logic [OW-1:0] head_q, head_d, tail_q, tail_d;
  logic [OW:0]   cnt_q, cnt_d;
  logic          en;

  always_comb begin
    en = clr_i | (push_n_i != '0) | (pop_n_i != '0);
    if (clr_i) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      head_d = (head_q + OW'(pop_n_i)) & mask_i;
      tail_d = (tail_q + OW'(push_n_i)) & mask_i;
      cnt_d  = cnt_q + (OW+1)'(push_n_i) - (OW+1)'(pop_n_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/smtfb_store.sv
module smtfb_store #(
  parameter int IW    = 16,
  parameter int GRP   = 8,
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int OW    = 6,
  parameter int GW    = 4
) (
  input  logic              clk,
  input  logic [GW-1:0]     we_n_i,
  input  logic [AW-1:0]     wr_base_i,
  input  logic [OW-1:0]     wr_off_i,
  input  logic [OW-1:0]     wr_mask_i,
  input  logic [GRP*IW-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_base_i,
  input  logic [OW-1:0]     rd_off_i,
  input  logic [OW-1:0]     rd_mask_i,
  output logic [GRP*IW-1:0] rd_data_o
);
  logic [IW-1:0] mem [DEPTH];
  logic [AW-1:0] wa [GRP];
  logic [AW-1:0] ra [GRP];

  always_comb begin
    for (int i = 0; i < GRP; i++) begin
      wa[i] = wr_base_i + AW'((wr_off_i + OW'(i)) & wr_mask_i);
      ra[i] = rd_base_i + AW'((rd_off_i + OW'(i)) & rd_mask_i);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < GRP; i++) begin
      if (GW'(i) < we_n_i) mem[wa[i]] <= wr_data_i[i*IW +: IW];
    end
  end

  for (genvar g = 0; g < GRP; g++) begin : g_lane
    assign rd_data_o[g*IW +: IW] = mem[ra[g]];
  end
endmodule

// File: rtl/smtfb_top.sv
module smtfb_top
  import smtfb_pkg::*;
#(
  parameter int IW    = 16,
  parameter int GRP   = 8,
  parameter int NTHR  = 8,
  parameter int DEPTH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_i,
  input  logic                     wr_valid_i,
  input  logic [$clog2(NTHR)-1:0]  wr_tid_i,
  input  logic [$clog2(GRP):0]     wr_cnt_i,
  input  logic [GRP*IW-1:0]        wr_data_i,
  output logic                     wr_accept_o,
  input  logic                     rd_req_i,
  input  logic [$clog2(NTHR)-1:0]  rd_tid_i,
  input  logic [$clog2(GRP):0]     rd_cnt_i,
  output logic [$clog2(GRP):0]     rd_num_o,
  output logic [GRP*IW-1:0]        rd_data_o,
  input  logic [NTHR-1:0]          flush_i,
  output logic [NTHR-1:0]          full_o,
  output logic [NTHR-1:0]          empty_o,
  output logic                     prefetch_off_o,
  output logic                     mode_err_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH / 2);
  localparam int CW = OW + 1;
  localparam int GW = $clog2(GRP) + 1;

  smt_mode_e mode_q, mode_d;
  logic      err_q, err_d;
  logic      mode_chg, mode_apply, all_empty;

  logic [CW-1:0] cap_all;
  logic [OW-1:0] mask;
  logic [NTHR-1:0] act;
  logic [CW-1:0] cap_t [NTHR];
  logic [AW-1:0] base  [NTHR];
  logic [OW-1:0] head  [NTHR];
  logic [OW-1:0] tail  [NTHR];
  logic [CW-1:0] cnt   [NTHR];
  logic [GW-1:0] push_n [NTHR];
  logic [GW-1:0] pop_n  [NTHR];
  logic [NTHR-1:0] clr;
  logic [GW-1:0] want;

  // region geometry for the applied mode
  always_comb begin
    cap_all = CW'(DEPTH >> region_shift(mode_q));
    mask    = OW'(cap_all - CW'(1));
    for (int t = 0; t < NTHR; t++) begin
      act[t]   = t < active_threads(mode_q);
      cap_t[t] = act[t] ? cap_all : '0;
      base[t]  = AW'(t * int'(cap_all));
      full_o[t]  = cnt[t] == cap_t[t];
      empty_o[t] = cnt[t] == '0;
    end
  end

  // mode change control
  always_comb begin
    all_empty  = &empty_o;
    mode_chg   = smt_mode_e'(mode_i) != mode_q;
    mode_apply = mode_chg & all_empty;
    mode_d     = mode_apply ? smt_mode_e'(mode_i) : mode_q;
    err_d      = mode_chg & ~all_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SMT_ONE;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  // write admission and read sizing
  always_comb begin
    wr_accept_o = wr_valid_i & ~mode_chg & act[wr_tid_i] & ~flush_i[wr_tid_i]
                & (wr_cnt_i != '0) & (wr_cnt_i <= GW'(GRP))
                & (CW'(wr_cnt_i) <= (cap_t[wr_tid_i] - cnt[wr_tid_i]));
    want = (rd_cnt_i > GW'(GRP)) ? GW'(GRP) : rd_cnt_i;
    if (!rd_req_i || flush_i[rd_tid_i])
      rd_num_o = '0;
    else if (CW'(want) > cnt[rd_tid_i])
      rd_num_o = GW'(cnt[rd_tid_i]);
    else
      rd_num_o = want;
    for (int t = 0; t < NTHR; t++) begin
      push_n[t] = (wr_accept_o && wr_tid_i == t[$clog2(NTHR)-1:0]) ? wr_cnt_i : '0;
      pop_n[t]  = (rd_tid_i == t[$clog2(NTHR)-1:0]) ? rd_num_o : '0;
      clr[t]    = flush_i[t] | mode_apply;
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    smtfb_region #(.OW(OW), .GW(GW)) u_rgn (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr[g]),
      .push_n_i (push_n[g]),
      .pop_n_i  (pop_n[g]),
      .mask_i   (mask),
      .head_o   (head[g]),
      .tail_o   (tail[g]),
      .count_o  (cnt[g])
    );
  end

  smtfb_store #(.IW(IW), .GRP(GRP), .DEPTH(DEPTH), .AW(AW), .OW(OW), .GW(GW)) u_store (
    .clk       (clk),
    .we_n_i    (wr_accept_o ? wr_cnt_i : '0),
    .wr_base_i (base[wr_tid_i]),
    .wr_off_i  (tail[wr_tid_i]),
    .wr_mask_i (mask),
    .wr_data_i (wr_data_i),
    .rd_base_i (base[rd_tid_i]),
    .rd_off_i  (head[rd_tid_i]),
    .rd_mask_i (mask),
    .rd_data_o (rd_data_o)
  );

  assign prefetch_off_o = mode_q == SMT_EIGHT;
  assign mode_err_o     = err_q;
endmodule

// File: rtl/smtfb_chk.sv
module smtfb_chk #(
  parameter int NTHR = 8,
  parameter int TW   = 3,
  parameter int GW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_q,
  input logic            wr_accept_o,
  input logic [TW-1:0]   wr_tid_i,
  input logic [GW-1:0]   rd_num_o,
  input logic [TW-1:0]   rd_tid_i,
  input logic [NTHR-1:0] flush_i,
  input logic [NTHR-1:0] full_o,
  input logic [NTHR-1:0] empty_o,
  input logic            prefetch_off_o,
  input logic            mode_err_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept_o |-> !full_o[wr_tid_i]); // R1
  AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept_o |=> !empty_o[$past(wr_tid_i)]); // R1
  AST_READ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_num_o != '0) |-> !empty_o[rd_tid_i]); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i != '0) |=> ((empty_o & $past(flush_i)) == $past(flush_i))); // R6
  AST_INACTIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> (&empty_o[NTHR-1:1])); // R2
  AST_PF_ONLY_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prefetch_off_o) |-> $past(&empty_o)); // R7
  AST_MODE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(&empty_o)); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> $past(!(&empty_o))); // R8
endmodule

bind smtfb_top smtfb_chk #(.NTHR(NTHR), .TW($clog2(NTHR)), .GW($clog2(GRP) + 1)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_q         (mode_q),
  .wr_accept_o    (wr_accept_o),
  .wr_tid_i       (wr_tid_i),
  .rd_num_o       (rd_num_o),
  .rd_tid_i       (rd_tid_i),
  .flush_i        (flush_i),
  .full_o         (full_o),
  .empty_o        (empty_o),
  .prefetch_off_o (prefetch_off_o),
  .mode_err_o     (mode_err_o)
);

// File: tb/smtfb_top_test.sv
module smtfb_top_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_i;
  logic         wr_valid_i;
  logic [2:0]   wr_tid_i;
  logic [3:0]   wr_cnt_i;
  logic [127:0] wr_data_i;
  logic         wr_accept_o;
  logic         rd_req_i;
  logic [2:0]   rd_tid_i;
  logic [3:0]   rd_cnt_i;
  logic [3:0]   rd_num_o;
  logic [127:0] rd_data_o;
  logic [7:0]   flush_i;
  logic [7:0]   full_o, empty_o;
  logic         prefetch_off_o, mode_err_o;

  smtfb_top uut (.*);

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // independent model of the per-thread FIFOs
  logic [15:0] mdl [8][64];
  int mh [8];
  int mc [8];
  int mm = 0;
  int seq = 0;
  logic [1:0] mode_sel = 2'd0;

  function automatic int cap_of(int t);
    int nact = 1 << mm;
    if (t >= nact) return 0;
    return 128 >> ((mm == 0) ? 1 : mm);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_status(input string req);
    logic [7:0] xf, xe;
    for (int t = 0; t < 8; t++) begin
      xe[t] = mc[t] == 0;
      xf[t] = mc[t] == cap_of(t);
    end
    chk(req, "empty_o", int'(empty_o), int'(xe));
    chk(req, "full_o", int'(full_o), int'(xf));
    chk("R7", "prefetch_off_o", int'(prefetch_off_o), int'(mm == 3));
  endtask

  task automatic step(input bit wv, input int tid, input int cnt, input bit rv, input int rtid,
                      input int rcnt, input logic [7:0] fl, input int xacc, input int xrd,
                      input string req);
    bit chg, allemp, pacc;
    int prd, cap, w;
    @(negedge clk);
    mode_i = mode_sel;
    wr_valid_i = wv; wr_tid_i = tid[2:0]; wr_cnt_i = cnt[3:0];
    for (int i = 0; i < 8; i++) wr_data_i[i*16 +: 16] = {tid[2:0], 13'(seq + i)};
    rd_req_i = rv; rd_tid_i = rtid[2:0]; rd_cnt_i = rcnt[3:0];
    flush_i = fl;
    #1;
    chg = int'(mode_sel) != mm;
    allemp = 1'b1;
    for (int t = 0; t < 8; t++) if (mc[t] != 0) allemp = 1'b0;
    pacc = wv && !chg && (cap_of(tid) > 0) && !fl[tid] && cnt >= 1 && cnt <= 8
           && cnt <= cap_of(tid) - mc[tid];
    prd = 0;
    if (rv && !fl[rtid]) begin
      prd = (rcnt > 8) ? 8 : rcnt;
      if (prd > mc[rtid]) prd = mc[rtid];
    end
    chk((req == "") ? "R1" : req, "wr_accept_o", int'(wr_accept_o), int'(pacc));
    if (xacc >= 0) chk("R1", "table accept", int'(wr_accept_o), xacc);
    chk((req == "") ? "R3" : req, "rd_num_o", int'(rd_num_o), prd);
    if (xrd >= 0) chk("R3", "table rd_num", int'(rd_num_o), xrd);
    cap = cap_of(rtid);
    for (int i = 0; i < prd; i++)
      chk("R3", "rd_data lane", int'(rd_data_o[i*16 +: 16]), int'(mdl[rtid][(mh[rtid] + i) % cap]));
    @(posedge clk);
    mh[rtid] = (cap > 0) ? (mh[rtid] + prd) % cap : 0;
    mc[rtid] -= prd;
    if (pacc) begin
      cap = cap_of(tid);
      for (int i = 0; i < cnt; i++) begin
        w = (mh[tid] + mc[tid] + i) % cap;
        mdl[tid][w] = {tid[2:0], 13'(seq + i)};
      end
      mc[tid] += cnt;
      seq += cnt;
    end
    for (int t = 0; t < 8; t++) if (fl[t]) begin mh[t] = 0; mc[t] = 0; end
    if (chg && allemp) begin
      mm = int'(mode_sel);
      for (int t = 0; t < 8; t++) begin mh[t] = 0; mc[t] = 0; end
    end
    #1;
    chk("R8", "mode_err_o", int'(mode_err_o), int'(chg && !allemp));
  endtask

  // {wv, tid, cnt, rv, rtid, rcnt, exp_accept, exp_rdnum}, single-thread mode
  localparam logic [20:0] VEC [6] = '{
    {1'b1, 3'd0, 4'd8, 1'b0, 3'd0, 4'd0, 1'b1, 4'd0},
    {1'b1, 3'd0, 4'd8, 1'b1, 3'd0, 4'd3, 1'b1, 4'd3},
    {1'b1, 3'd1, 4'd4, 1'b1, 3'd0, 4'd8, 1'b0, 4'd8},
    {1'b0, 3'd0, 4'd0, 1'b1, 3'd0, 4'd8, 1'b0, 4'd5},
    {1'b0, 3'd0, 4'd0, 1'b1, 3'd0, 4'd4, 1'b0, 4'd0},
    {1'b1, 3'd0, 4'd9, 1'b0, 3'd0, 4'd0, 1'b0, 4'd0}
  };

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 8; t++) begin mh[t] = 0; mc[t] = 0; end
    rst_n = 1'b0; mode_i = 2'd0; wr_valid_i = 1'b0; wr_tid_i = '0; wr_cnt_i = '0;
    wr_data_i = '0; rd_req_i = 1'b0; rd_tid_i = '0; rd_cnt_i = '0; flush_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9", "empty_o", int'(empty_o), 8'hFF);
    chk("R9", "full_o", int'(full_o), 8'hFE);
    chk("R9", "prefetch_off_o", int'(prefetch_off_o), 0);
    chk("R9", "mode_err_o", int'(mode_err_o), 0);
    chk("R9", "rd_num_o", int'(rd_num_o), 0);

    foreach (VEC[k]) begin
      logic [20:0] v;
      v = VEC[k];
      step(v[20], int'(v[19:17]), int'(v[16:13]), v[12], int'(v[11:9]), int'(v[8:5]),
           8'h00, int'(v[4]), int'(v[3:0]), "R1");
    end
    chk_status("R5");

    // R1 fill thread 0 to 64, overshoot by one, then exact fit across the wrap
    for (int k = 0; k < 8; k++) step(1, 0, 8, 0, 0, 0, 8'h00, 1, -1, "R1");
    chk_status("R5");
    step(1, 0, 1, 0, 0, 0, 8'h00, 0, -1, "R1");
    step(0, 0, 0, 1, 0, 5, 8'h00, -1, 5, "R3");
    step(1, 0, 8, 0, 0, 0, 8'h00, 0, -1, "R1");
    step(1, 0, 6, 0, 0, 0, 8'h00, 0, -1, "R1");
    step(1, 0, 5, 0, 0, 0, 8'h00, 1, -1, "R1");
    chk_status("R5");
    for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 0, 8, 8'h00, -1, 8, "R3");
    chk_status("R5");

    // R8 mode request refused while thread 0 holds data
    step(1, 0, 3, 0, 0, 0, 8'h00, 1, -1, "R1");
    mode_sel = 2'd3;
    step(1, 0, 2, 0, 0, 0, 8'h00, 0, -1, "R8");
    chk("R8", "mode kept", int'(prefetch_off_o), 0);
    mode_sel = 2'd0;
    step(1, 1, 2, 0, 0, 0, 8'h00, 0, -1, "R2");
    // R6 flush beats a same-cycle write and read
    step(1, 0, 2, 1, 0, 2, 8'h01, 0, 0, "R6");
    chk_status("R6");

    // R7 eight-thread mode, 16 slots per thread
    mode_sel = 2'd3;
    step(0, 0, 0, 0, 0, 0, 8'h00, -1, -1, "R8");
    chk_status("R7");
    step(1, 5, 8, 0, 0, 0, 8'h00, 1, -1, "R2");
    step(1, 5, 8, 0, 0, 0, 8'h00, 1, -1, "R2");
    step(1, 5, 1, 0, 0, 0, 8'h00, 0, -1, "R2");
    step(1, 2, 4, 0, 0, 0, 8'h00, 1, -1, "R4");
    chk_status("R5");
    step(0, 0, 0, 0, 0, 0, 8'h20, -1, -1, "R6");
    chk_status("R4");
    step(0, 0, 0, 1, 2, 8, 8'h00, -1, 4, "R4");

    // R2 two-thread mode: each thread keeps 64 of its own
    mode_sel = 2'd1;
    step(0, 0, 0, 0, 0, 0, 8'h00, -1, -1, "R8");
    for (int k = 0; k < 8; k++) step(1, 1, 8, 0, 0, 0, 8'h00, 1, -1, "R2");
    for (int k = 0; k < 8; k++) step(1, 0, 8, 0, 0, 0, 8'h00, 1, -1, "R2");
    chk_status("R2");
    step(1, 2, 1, 1, 0, 8, 8'h00, 0, 8, "R2");
    step(1, 1, 1, 0, 0, 0, 8'h00, 0, -1, "R1");
    for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 1, 8, 8'h00, -1, 8, "R4");
    step(0, 0, 0, 0, 0, 0, 8'hFF, -1, -1, "R6");

    // four-thread mode: 32 slots, threads 4..7 inactive
    mode_sel = 2'd2;
    step(0, 0, 0, 0, 0, 0, 8'h00, -1, -1, "R8");
    for (int k = 0; k < 4; k++) step(1, 3, 8, 0, 0, 0, 8'h00, 1, -1, "R2");
    step(1, 3, 1, 0, 0, 0, 8'h00, 0, -1, "R2");
    step(1, 4, 1, 0, 0, 0, 8'h00, 0, -1, "R2");
    chk_status("R5");
    step(0, 0, 0, 1, 3, 12, 8'h00, -1, 8, "R3");
    step(0, 0, 0, 0, 0, 0, 8'h00, -1, -1, "R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule